// File: doc/BRIEF.md
# Indexed Host Register Port

This block is the host-facing slave of a device whose internal registers are not mapped one by one into the host address space. The host sees exactly two locations on a shared data bus. One address bit acts as the command line: with that bit low the access goes to the index port, and with it high the access goes to the data port. To reach a register, the host first writes the register number to the index port. Every later data-port read or write then goes to that register, until the host writes a new index.

On the device side the block drives a plain register bus. It has an address, a write pulse, a read pulse and write data, and it takes read data back combinationally. The host bus width is a parameter and is either 8 or 16 bits. The index is 8 bits wide. Read results are registered, so they are valid on the host side one clock after the read strobe. They hold until the next read access.

Top module: `idx_host_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the index is 0x00 and host_rdata is all zeros.
- R2: host_addr bit 2 is the command line. When it is 0 the access targets the index port, and when it is 1 the access targets the data port. All other address bits have no effect, so offsets 0x0 and 0x8 both reach the index port and offsets 0x4 and 0xC both reach the data port.
- R3: An index-port write loads host_wdata bits 7:0 into the index. On a 16-bit bus, bits 15:8 are discarded.
- R4: A data-port write raises reg_wr for exactly that clock cycle. During that cycle reg_addr equals the current index and reg_wdata equals host_wdata.
- R5: A data-port read raises reg_rd for that clock cycle, with reg_addr equal to the current index. The reg_rdata value sampled at that edge appears on host_rdata after the edge and holds until the next read access.
- R6: An index-port read returns the current index on host_rdata after the edge, zero-extended to the bus width. It raises neither reg_rd nor reg_wr.
- R7: The index keeps its value across any number of data-port accesses.
- R8: While host_cs is 0, no strobe reaches the register bus, and neither the index nor host_rdata changes.
- R9: A cycle with host_cs, host_rd and host_wr all at 1 is not an access. It raises no register strobe and changes neither the index nor host_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Chip select, active high |
| host_rd | input | 1 | Read strobe, one access per cycle it is high |
| host_wr | input | 1 | Write strobe, one access per cycle it is high |
| host_addr | input | ADDR_W (8) | Host address; bit CMD_BIT (2) is the command line |
| host_wdata | input | BUS_W (16) | Host write data |
| host_rdata | output | BUS_W (16) | Registered host read data |
| reg_addr | output | IDX_W (8) | Register bus address (the latched index) |
| reg_wr | output | 1 | Register bus write pulse |
| reg_rd | output | 1 | Register bus read pulse |
| reg_wdata | output | BUS_W (16) | Register bus write data |
| reg_rdata | input | BUS_W (16) | Register bus read data, combinational from the register file |

## Verification
The bench writes an index through an offset that has bit 3 set and then uses the data port at a different offset with bit 3 set. A decode that looked at more than bit 2 would send these accesses to the wrong port. It writes an index with a non-zero upper byte and reads the index back; a design that kept 16 bits would return the upper byte. It then repeats several data writes and reads without re-indexing, which catches an index that is cleared or advanced by data traffic. It also drives writes and reads with chip select low, and with both strobes high together. A design that leaked either case would change the index, pulse the register bus or disturb the held read data, and the scoreboard would see a wrong value on the next read.

// File: rtl/idx_port_pkg.sv
// Package: shared types for the indexed host register port.
// Assumes: one host access per cycle, qualified by chip select.
package idx_port_pkg;

    // Kind of host access decoded for one clock cycle
    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_IDX_WR = 3'd1,
        ACC_IDX_RD = 3'd2,
        ACC_DAT_WR = 3'd3,
        ACC_DAT_RD = 3'd4
    } acc_kind_e;

endpackage

// File: rtl/idx_cmd_decode.sv
// Module: idx_cmd_decode
// Turns chip select, strobes and the command address bit into one access
// kind per cycle. Assumes the strobes are already synchronous to clk.
// A cycle with both strobes high, or chip select low, is no access.
module idx_cmd_decode
    import idx_port_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CMD_BIT = 2
) (
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);

    logic cmd_hi;
    logic addr_unused;

    assign cmd_hi      = addr[CMD_BIT];
    assign addr_unused = ^addr;

    // Classify the access: port chosen by the command bit, direction by strobe
    always_comb begin
        kind = ACC_NONE;
        if (cs && (rd ^ wr)) begin
            if (cmd_hi) begin
                kind = wr ? ACC_DAT_WR : ACC_DAT_RD;
            end else begin
                kind = wr ? ACC_IDX_WR : ACC_IDX_RD;
            end
        end
    end

endmodule

// File: rtl/idx_index_reg.sv
// Module: idx_index_reg
// Holds the register number selected by the host. Loads only on an
// index-port write and keeps its value otherwise. Assumes load_val is
// already cut down to the index width by the caller.
module idx_index_reg #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] idx
);

    // Index storage: clear on reset, capture on index write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_val;
        end
    end

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx == $past(load_val)));   // R3

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(idx));              // R7

endmodule

// File: rtl/idx_read_return.sv
// Module: idx_read_return
// Registers the value returned to the host. A data read captures the
// register bus data and an index read captures the zero-extended index.
// Any other cycle holds the last value. Assumes IDX_W <= BUS_W.
module idx_read_return
    import idx_port_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] bus_rdata,
    output logic [BUS_W-1:0] host_rdata
);

    logic [BUS_W-1:0] idx_ext;

    // Widen the index to the host bus width when the bus is wider
    generate
        if (BUS_W > IDX_W) begin : g_ext
            assign idx_ext = {{(BUS_W-IDX_W){1'b0}}, idx};
        end else begin : g_same
            assign idx_ext = idx;
        end
    endgenerate

    // Read-return register: updated only by read accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else begin
            case (kind)
                ACC_DAT_RD: host_rdata <= bus_rdata;
                ACC_IDX_RD: host_rdata <= idx_ext;
                default:    host_rdata <= host_rdata;
            endcase
        end
    end

    AST_DAT_RD_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DAT_RD) |=> (host_rdata == $past(bus_rdata)));  // R5

    AST_IDX_RD_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_IDX_RD) |=> (host_rdata == $past(idx_ext)));    // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_DAT_RD && kind != ACC_IDX_RD) |=> $stable(host_rdata)); // R5

endmodule

// File: rtl/idx_host_port.sv
// Module: idx_host_port (top)
// Host slave with two ports on one data bus. The command address bit
// selects between the index port, which latches a register number, and
// the data port, which passes accesses to that register on the internal
// register bus. Assumes the register file answers reg_rdata combinationally
// from reg_addr, and that BUS_W is 8 or 16.
module idx_host_port
    import idx_port_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int IDX_W   = 8,
    parameter int ADDR_W  = 8,
    parameter int CMD_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BUS_W-1:0]  host_wdata,
    output logic [BUS_W-1:0]  host_rdata,
    output logic [IDX_W-1:0]  reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [BUS_W-1:0]  reg_wdata,
    input  logic [BUS_W-1:0]  reg_rdata
);

    acc_kind_e        kind;
    logic [IDX_W-1:0] idx_q;

    // Parameter sanity: supported bus widths and index fits in the bus
    initial begin
        AST_PARAM_OK: assert ((BUS_W == 8 || BUS_W == 16) && IDX_W <= BUS_W
                              && CMD_BIT < ADDR_W); // R2
    end

    idx_cmd_decode #(
        .ADDR_W  (ADDR_W),
        .CMD_BIT (CMD_BIT)
    ) u_decode (
        .cs   (host_cs),
        .rd   (host_rd),
        .wr   (host_wr),
        .addr (host_addr),
        .kind (kind)
    );

    idx_index_reg #(
        .IDX_W (IDX_W)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (kind == ACC_IDX_WR),
        .load_val (host_wdata[IDX_W-1:0]),
        .idx      (idx_q)
    );

    idx_read_return #(
        .BUS_W (BUS_W),
        .IDX_W (IDX_W)
    ) u_rret (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .idx        (idx_q),
        .bus_rdata  (reg_rdata),
        .host_rdata (host_rdata)
    );

    // Register bus drive: address is always the index, strobes per access
    always_comb begin
        reg_addr  = idx_q;
        reg_wdata = host_wdata;
        reg_wr    = (kind == ACC_DAT_WR);
        reg_rd    = (kind == ACC_DAT_RD);
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr}));                                   // R4

    AST_NO_CS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |-> (!reg_rd && !reg_wr));                            // R8

    AST_NO_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |=> ($stable(reg_addr) && $stable(host_rdata)));     // R8

    AST_RW_CLASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_rd && host_wr) |-> (!reg_rd && !reg_wr));     // R9

    AST_WR_CMD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (host_cs && host_wr && host_addr[CMD_BIT]));       // R2

endmodule

// File: tb/idx_host_port_tb_top.sv
// Scoreboard bench for idx_host_port. The driver task issues host accesses,
// checks the register bus strobes within the access cycle, and pushes the
// expected host_rdata. A monitor pops and compares one cycle later.
module idx_host_port_tb_top;

    localparam int BW = 16;
    localparam int IW = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_cs, host_rd, host_wr;
    logic [AW-1:0] host_addr;
    logic [BW-1:0] host_wdata;
    logic [BW-1:0] host_rdata;
    logic [IW-1:0] reg_addr;
    logic          reg_wr, reg_rd;
    logic [BW-1:0] reg_wdata;
    logic [BW-1:0] reg_rdata;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [BW-1:0] slv [256];
    logic [BW-1:0] mdl [256];
    logic [IW-1:0] exp_idx;
    logic [BW-1:0] exp_rdata;

    logic [BW-1:0] sb_val[$];
    string         sb_tag[$];

    always #5 clk = ~clk;

    idx_host_port #(.BUS_W(BW), .IDX_W(IW), .ADDR_W(AW), .CMD_BIT(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs    (host_cs),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    // Register file model on the internal bus
    assign reg_rdata = slv[reg_addr];
    always @(posedge clk) if (reg_wr) slv[reg_addr] <= reg_wdata;

    task automatic chk(input logic [BW-1:0] act, input logic [BW-1:0] exp,
                       input string tag, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: one host access, strobe checks, expected read value pushed
    task automatic host_access(input logic cs, input logic rd, input logic wr,
                               input logic [AW-1:0] addr, input logic [BW-1:0] wd,
                               input string tag);
        logic valid, cmd, e_wr, e_rd;
        @(negedge clk);
        host_cs = cs; host_rd = rd; host_wr = wr;
        host_addr = addr; host_wdata = wd;
        valid = cs && (rd ^ wr);
        cmd   = addr[2];
        e_wr  = valid && wr && cmd;
        e_rd  = valid && rd && cmd;
        #1;
        chk({15'd0, reg_wr}, {15'd0, e_wr}, tag, "reg_wr");
        chk({15'd0, reg_rd}, {15'd0, e_rd}, tag, "reg_rd");
        if (e_wr || e_rd) chk({8'd0, reg_addr}, {8'd0, exp_idx}, tag, "reg_addr");
        if (e_wr) chk(reg_wdata, wd, tag, "reg_wdata");
        if (valid) begin
            if (wr && !cmd) exp_idx = wd[IW-1:0];
            else if (wr && cmd) mdl[exp_idx] = wd;
            else if (rd && !cmd) exp_rdata = {8'd0, exp_idx};
            else exp_rdata = mdl[exp_idx];
        end
        @(posedge clk);
        sb_val.push_back(exp_rdata);
        sb_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            host_cs = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
        end
    endtask

    // Monitor: compare host_rdata against the scoreboard away from the edge
    always @(negedge clk) begin
        if (sb_val.size() != 0) begin
            chk(host_rdata, sb_val.pop_front(), sb_tag.pop_front(), "host_rdata");
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            slv[i] = BW'((i * 16'h0101) ^ 16'h5A3C);
            mdl[i] = BW'((i * 16'h0101) ^ 16'h5A3C);
        end
        exp_idx = '0; exp_rdata = '0;
        host_cs = 0; host_rd = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(host_rdata, 16'h0000, "R1", "rdata after reset");
        host_access(1, 1, 0, 8'h00, 16'h0, "R1");          // index reads 0
        host_access(1, 1, 0, 8'h04, 16'h0, "R1");          // data from reg 0

        // R4/R5: index, write, read back
        host_access(1, 0, 1, 8'h00, 16'h0010, "R3");
        host_access(1, 0, 1, 8'h04, 16'h1234, "R4");
        host_access(1, 1, 0, 8'h04, 16'h0, "R5");
        idle(2);                                           // R5 hold

        // R7: several data accesses, same index
        host_access(1, 0, 1, 8'h04, 16'hBEEF, "R7");
        host_access(1, 1, 0, 8'h04, 16'h0, "R7");
        host_access(1, 0, 1, 8'h04, 16'hC0DE, "R7");
        host_access(1, 1, 0, 8'h04, 16'h0, "R7");
        host_access(1, 1, 0, 8'h00, 16'h0, "R7");          // index still 0x10

        // R2: other address bits ignored
        host_access(1, 0, 1, 8'h08, 16'h0021, "R2");
        host_access(1, 1, 0, 8'h0C, 16'h0, "R2");
        host_access(1, 0, 1, 8'h8C, 16'h7777, "R2");
        host_access(1, 1, 0, 8'h84, 16'h0, "R2");

        // R3/R6: upper byte of index write discarded
        host_access(1, 0, 1, 8'h00, 16'hFF3A, "R3");
        host_access(1, 1, 0, 8'h00, 16'h0, "R6");

        // R8: chip select low
        host_access(0, 0, 1, 8'h00, 16'h0055, "R8");
        host_access(0, 0, 1, 8'h04, 16'hDEAD, "R8");
        host_access(0, 1, 0, 8'h00, 16'h0, "R8");
        host_access(1, 1, 0, 8'h00, 16'h0, "R8");
        host_access(1, 1, 0, 8'h04, 16'h0, "R8");

        // R9: both strobes together
        host_access(1, 1, 1, 8'h00, 16'h0066, "R9");
        host_access(1, 1, 1, 8'h04, 16'hFACE, "R9");
        host_access(1, 1, 0, 8'h00, 16'h0, "R9");
        host_access(1, 1, 0, 8'h04, 16'h0, "R9");

        // R4/R5 sweep over several indices
        for (int j = 0; j < 16; j++) begin
            host_access(1, 0, 1, 8'h00, BW'(j * 17), "R3");
            host_access(1, 0, 1, 8'h04, BW'(16'hA000 + j), "R4");
        end
        for (int j = 0; j < 16; j++) begin
            host_access(1, 0, 1, 8'h00, BW'(j * 17), "R3");
            host_access(1, 1, 0, 8'h04, 16'h0, "R5");
        end

        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule